// File: doc/BRIEF.md
# Fine-grained read trap checker

This block holds the hypervisor's control word that decides, one guarded system register at a time, whether a read issued from the guest kernel privilege level is diverted to the hypervisor. Fifteen registers are guarded, each by one bit of a 64-bit word. The remaining upper bits are reserved. The enable bits are active-low: after reset every guarded read from the guest traps, and the hypervisor sets a bit to let reads of that register through.

For each request strobe, the block produces one registered response a cycle later. The response carries a trap flag, a 6-bit exception class and an illegal-opcode flag. One register, index 2, also accepts a paired-width read, which is reported with its own exception class. Each guarded bit depends on a feature being present. When that feature is absent, the bit is forced to zero on write and on read, and reads of that register are not trapped by this block. Instruction decode and exception delivery are handled elsewhere.

Top module: `rd_trap_gate`

## Requirements
- R1: `cfg_rdata[63:15]` always reads zero, whatever value was written to those bits.
- R2: Reset clears the control word to all zeros, so after reset a guest read of any present register traps.
- R3: A control bit of 0 traps a guest read of its register. A control bit of 1 lets the read through (`rsp_trap`=0).
- R4: A trap is raised only when `req_lvl`=1 (guest kernel) and `hyp_en`=1. Levels 0 (user), 2 (hypervisor) and 3 (top) never trap.
- R5: A trapped single-width read (`req_pair`=0) reports `rsp_ec`=0x18. Any response without a trap reports `rsp_ec`=0.
- R6: A trapped paired-width read (`req_pair`=1) of index 2 reports `rsp_ec`=0x14.
- R7: A paired-width read of any index other than 2 sets `rsp_illegal`=1 and `rsp_trap`=0, at every privilege level.
- R8: When `hi_pri_exc`=1 with the request, no trap is reported.
- R9: `feat_present[3]` enables bits 14..3, and `feat_present[2..0]` enable bits 2..0 one each. An absent bit reads zero. A write to an absent bit stores zero. A read of that register never traps.
- R10: Each request strobe gives exactly one response with `rsp_valid`=1 on the following cycle, including back-to-back strobes. Index 15 guards nothing and never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 64 | Control word write data |
| cfg_rdata | output | 64 | Control word read-back, with reserved and absent bits zero |
| feat_present | input | 4 | Feature-present flags: [3] for bits 14..3, [2:0] for bits 2..0 |
| req_valid | input | 1 | Read request strobe |
| req_idx | input | 4 | Guarded register index |
| req_pair | input | 1 | 1 = paired-width read, 0 = single-width read |
| req_lvl | input | 2 | Requesting privilege level (0 user, 1 guest kernel, 2 hypervisor, 3 top) |
| hyp_en | input | 1 | Hypervisor level implemented and enabled in the current security state |
| hi_pri_exc | input | 1 | The read already raises a higher-priority exception |
| rsp_valid | output | 1 | Response valid, one cycle after `req_valid` |
| rsp_trap | output | 1 | Read is diverted to the hypervisor |
| rsp_illegal | output | 1 | Paired-width read of a register that does not support it |
| rsp_ec | output | 6 | Exception class for a trap, otherwise 0 |

## Verification
The hardest case to reach is a guarded bit that is written while its feature is absent and read back after the feature returns. The expected result is that the bit stays zero, so the register now traps. The bench first drops `feat_present[3]` and writes all ones. It then restores the feature, checks that only bits 2..0 read back, and confirms that a guest read of index 10 traps. A second hard case is a paired-width read of index 2 with bit 2 cleared, issued back-to-back with single-width reads. This checks that the 0x14 class stays attached to the correct response.

// File: rtl/rd_trap_gate.sv
module rd_trap_gate #(
  parameter int WORD_W   = 64,
  parameter int GUARD_N  = 15,
  parameter int IDX_W    = 4,
  parameter int PAIR_IDX = 2,
  parameter logic [5:0] EC_SINGLE = 6'h18,
  parameter logic [5:0] EC_PAIR   = 6'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [3:0]        feat_present,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_pair,
  input  logic [1:0]        req_lvl,
  input  logic              hyp_en,
  input  logic              hi_pri_exc,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic              rsp_illegal,
  output logic [5:0]        rsp_ec
);
  localparam int SHARED_N = GUARD_N - 3;
  localparam int SLOT_N   = 1 << IDX_W;
  localparam int PAD_N    = SLOT_N - GUARD_N;
  localparam logic [1:0] LVL_GUEST = 2'd1;

  logic [GUARD_N-1:0] ctl_q;
  logic [GUARD_N-1:0] present;
  logic [GUARD_N-1:0] ctl_eff;
  logic [SLOT_N-1:0]  present_slot;
  logic [SLOT_N-1:0]  ctl_slot;
  logic               illegal_d;
  logic               trap_d;

  assign present      = {{SHARED_N{feat_present[3]}}, feat_present[2:0]};
  assign ctl_eff      = ctl_q & present;
  assign cfg_rdata    = {{(WORD_W-GUARD_N){1'b0}}, ctl_eff};
  assign present_slot = {{PAD_N{1'b0}}, present};
  assign ctl_slot     = {{PAD_N{1'b1}}, ctl_eff};

  assign illegal_d = req_pair && (req_idx != IDX_W'(PAIR_IDX));
  assign trap_d    = !illegal_d && (req_lvl == LVL_GUEST) && hyp_en && !hi_pri_exc
                     && present_slot[req_idx] && !ctl_slot[req_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (cfg_we) begin
      ctl_q <= cfg_wdata[GUARD_N-1:0] & present;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_trap    <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_ec      <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_trap    <= req_valid && trap_d;
      rsp_illegal <= req_valid && illegal_d;
      rsp_ec      <= (req_valid && trap_d) ? (req_pair ? EC_PAIR : EC_SINGLE) : '0;
    end
  end
endmodule

module rd_trap_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] cfg_rdata,
  input logic        req_valid,
  input logic [1:0]  req_lvl,
  input logic        req_pair,
  input logic        hyp_en,
  input logic        hi_pri_exc,
  input logic        rsp_valid,
  input logic        rsp_trap,
  input logic        rsp_illegal,
  input logic [5:0]  rsp_ec
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[63:15] == '0);
  a_r4_guest_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_lvl != 2'd1 || !hyp_en) |=> !rsp_trap);
  a_r5_ec_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_pair |=> (rsp_trap ? rsp_ec == 6'h18 : rsp_ec == 6'h00));
  a_r6_ec_pair: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_pair |=> (!rsp_trap || rsp_ec == 6'h14));
  a_r7_illegal_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_trap && rsp_illegal));
  a_r8_hipri: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hi_pri_exc |=> !rsp_trap);
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_trap && !rsp_illegal);
endmodule

bind rd_trap_gate rd_trap_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
  .req_lvl(req_lvl), .req_pair(req_pair), .hyp_en(hyp_en), .hi_pri_exc(hi_pri_exc),
  .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_illegal(rsp_illegal), .rsp_ec(rsp_ec)
);

// File: tb/rd_trap_gate_bench.sv
`timescale 1ns/1ps
module rd_trap_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic [3:0]  feat_present = 4'b1111;
  logic        req_valid = 1'b0;
  logic [3:0]  req_idx = '0;
  logic        req_pair = 1'b0;
  logic [1:0]  req_lvl = '0;
  logic        hyp_en = 1'b0;
  logic        hi_pri_exc = 1'b0;
  logic        rsp_valid, rsp_trap, rsp_illegal;
  logic [5:0]  rsp_ec;

  int n_checks = 0;
  int n_errors = 0;
  logic [14:0] mdl_ctl = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rd_trap_gate u_rd_trap_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .feat_present(feat_present), .req_valid(req_valid), .req_idx(req_idx), .req_pair(req_pair),
    .req_lvl(req_lvl), .hyp_en(hyp_en), .hi_pri_exc(hi_pri_exc), .rsp_valid(rsp_valid),
    .rsp_trap(rsp_trap), .rsp_illegal(rsp_illegal), .rsp_ec(rsp_ec)
  );

  function automatic logic [14:0] pmask(input logic [3:0] f);
    return {{12{f[3]}}, f[2:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = d;
    mdl_ctl = d[14:0] & pmask(feat_present);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [3:0] idx, input logic pair, input logic [1:0] lvl,
                       input logic hyp, input logic hpe, input string tag);
    logic ill, trp;
    logic [15:0] pm, cm;
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_pair = pair; req_lvl = lvl;
    hyp_en = hyp; hi_pri_exc = hpe;
    pm = {1'b0, pmask(feat_present)};
    cm = {1'b1, mdl_ctl & pmask(feat_present)};
    ill = pair && idx != 4'd2;
    trp = !ill && lvl == 2'd1 && hyp && !hpe && pm[idx] && !cm[idx];
    exp_q.push_back({trp, ill, trp ? (pair ? 6'h14 : 6'h18) : 6'h00});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", 64'(rsp_valid), 64'h0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'({rsp_trap, rsp_illegal, rsp_ec}), 64'(e));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset word", cfg_rdata, 64'h0);
    check("R10 reset valid", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    issue(4'd5, 0, 2'd1, 1, 0, "R2 R3 trap after reset");
    issue(4'd14, 0, 2'd1, 1, 0, "R5 single ec");
    idle(2);
    write_ctl(64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 reserved bits read zero", cfg_rdata, 64'h7FFF);
    issue(4'd5, 0, 2'd1, 1, 0, "R3 set bit passes");
    idle(2);
    write_ctl(64'hFFFF_0000_0000_7DFB);
    check("R1 reserved write ignored", cfg_rdata, 64'h7DFB);
    issue(4'd9, 0, 2'd1, 1, 0, "R3 cleared bit traps");
    issue(4'd8, 0, 2'd1, 1, 0, "R3 neighbour passes");
    issue(4'd9, 0, 2'd0, 1, 0, "R4 user level");
    issue(4'd9, 0, 2'd2, 1, 0, "R4 hyp level");
    issue(4'd9, 0, 2'd3, 1, 0, "R4 top level");
    issue(4'd9, 0, 2'd1, 0, 0, "R4 hyp disabled");
    issue(4'd9, 0, 2'd1, 1, 1, "R8 higher priority");
    issue(4'd2, 1, 2'd1, 1, 0, "R6 paired trap");
    issue(4'd2, 0, 2'd1, 1, 0, "R5 single at idx2");
    issue(4'd9, 1, 2'd1, 1, 0, "R7 paired illegal");
    issue(4'd0, 1, 2'd3, 1, 0, "R7 paired illegal top");
    issue(4'd15, 0, 2'd1, 1, 0, "R10 idx15 no trap");
    idle(3);
    check("R10 valid drops", 64'(rsp_valid), 64'h0);
    write_ctl(64'h7FFF);
    issue(4'd2, 1, 2'd1, 1, 0, "R6 paired passes when set");
    idle(2);
    write_ctl(64'h0);
    @(negedge clk);
    feat_present = 4'b1011;
    issue(4'd2, 0, 2'd1, 1, 0, "R9 absent bit no trap");
    issue(4'd1, 0, 2'd1, 1, 0, "R9 present bit traps");
    idle(2);
    feat_present = 4'b0111;
    write_ctl(64'hFFFF);
    check("R9 absent bits read zero", cfg_rdata, 64'h0007);
    issue(4'd10, 0, 2'd1, 1, 0, "R9 absent shared no trap");
    idle(2);
    feat_present = 4'b1111;
    @(negedge clk);
    check("R9 absent write stored zero", cfg_rdata, 64'h0007);
    issue(4'd10, 0, 2'd1, 1, 0, "R9 restored bit traps");
    issue(4'd0, 0, 2'd1, 1, 0, "R9 written bit passes");
    idle(3);
    check("R10 queue drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule